// File: doc/BRIEF.md
# Selectable-Ratio Serial-to-Parallel Word Assembler

This block collects a serial bit stream, one bit per qualifying strobe of the system clock, and hands it on as a parallel word of 16, 10, 8 or 4 bits. Two static select inputs choose the word length at run time. A short word is placed on a fixed group of lanes of the 16-lane output. Each finished word comes out with a parity bit whose sense can be programmed. The word can also be muted to all zeros, and its lane order can be mirrored.

The serial input comes from one of two sources. One is the recovered data with its bit strobe. The other is a loop-mode data and strobe pair, selected by an active-low loopback enable. The serial clock is modelled as a one-cycle strobe (`*_tick`) in the core clock domain.

Assembly is held in a two-state machine. `ST_EMPTY` waits for the first bit of a word. On a strobe it takes the transition *first-bit* to `ST_FILL`. `ST_FILL` gathers further bits. When the last bit of the word arrives it takes the transition *word-complete* back to `ST_EMPTY`. A change of ratio takes the transition *ratio-restart* to `ST_EMPTY` from either state. This transition clears the partial word and the bit counter, and any bit strobe in that same cycle is dropped.

Top module: `word_deser`

## Requirements
- R1: `ratio_sel` selects the word length N: 2'b11 gives 16, 2'b10 gives 10, 2'b01 gives 8 and 2'b00 gives 4. `word_stb` pulses once for every N accepted bit strobes.
- R2: After reset, `par_word`, `par_bit` and `word_stb` are all 0.
- R3: The first bit of a word lands in the most significant active lane and later bits follow in descending lane order. For N = 16 the lanes are 15..0, for N = 10 they are 9..0 and for N = 8 they are 7..0. Inactive lanes read 0.
- R4: For N = 4 the bits occupy lanes 9..6, with the first bit on lane 9. Every other lane reads 0.
- R5: `par_bit` is computed over the active lanes. With `odd_par` = 0, the count of ones in the word plus `par_bit` is even. With `odd_par` = 1, that count is odd.
- R6: With `mirror` = 1, the bit that would appear on lane n appears on lane 15−n.
- R7: With `mute` = 1, every lane of `par_word` is 0 and `par_bit` equals `odd_par`.
- R8: With `loop_en_n` = 0, bits and strobes come only from `lb_bit`/`lb_tick`, and activity on `rx_bit`/`rx_tick` has no effect. With `loop_en_n` = 1, the reverse holds.
- R9: A change of `ratio_sel` discards the partial word. The next word starts with the first strobe that follows the change.
- R10: `word_stb` is high for exactly one cycle, in the cycle after the edge that takes the last bit. `par_word` and `par_bit` hold their values until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit | input | 1 | Recovered serial data |
| rx_tick | input | 1 | Recovered bit strobe |
| lb_bit | input | 1 | Loop-mode serial data |
| lb_tick | input | 1 | Loop-mode bit strobe |
| loop_en_n | input | 1 | Selects the loop-mode pair when low |
| ratio_sel | input | 2 | Word length select |
| mute | input | 1 | Forces the parallel word to zero |
| mirror | input | 1 | Reverses the lane order |
| odd_par | input | 1 | 1 selects odd parity, 0 selects even parity |
| par_word | output | 16 | Parallel word |
| par_bit | output | 1 | Parity of the word |
| word_stb | output | 1 | One-cycle word-valid strobe |

## Verification
The bench builds the block with its default 16 lanes and the narrow group based at lane 6. At this size every ratio × mirror × mute × parity-sense combination can be swept with several bit patterns. Every word is compared against a lane map computed arithmetically in the bench. The same size makes the remaining cases cheap to reach: a restart in the middle of a word, loop-mode selection while the recovered path carries conflicting traffic, and the strobe spacing inside each word.

// File: rtl/deser_pkg.sv
package deser_pkg;

    typedef enum logic [1:0] {
        RATIO_4  = 2'b00,
        RATIO_8  = 2'b01,
        RATIO_10 = 2'b10,
        RATIO_16 = 2'b11
    } ratio_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FILL  = 1'b1
    } asm_state_e;

    function automatic int unsigned ratio_len(ratio_e r);
        case (r)
            RATIO_4:  return 4;
            RATIO_8:  return 8;
            RATIO_10: return 10;
            default:  return 16;
        endcase
    endfunction

endpackage

// File: rtl/deser_src_sel.sv
module deser_src_sel (
    input  logic rec_bit,
    input  logic rec_tick,
    input  logic alt_bit,
    input  logic alt_tick,
    input  logic use_alt_n,
    output logic sel_bit,
    output logic sel_tick
);
    always_comb begin
        if (use_alt_n) begin
            sel_bit  = rec_bit;
            sel_tick = rec_tick;
        end else begin
            sel_bit  = alt_bit;
            sel_tick = alt_tick;
        end
    end
endmodule

// File: rtl/deser_core.sv
module deser_core
    import deser_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ratio_e           ratio_sel,
    input  logic             in_bit,
    input  logic             in_tick,
    output logic [LANES-1:0] raw_word,
    output logic             word_done,
    output ratio_e           ratio_q
);
    localparam int CW = $clog2(LANES + 1);

    asm_state_e       state, state_n;
    logic [CW-1:0]    cnt, cnt_n;
    logic [LANES-1:0] sr, sr_n;
    logic [CW-1:0]    len_c;
    logic             ratio_chg;

    assign len_c     = CW'(ratio_len(ratio_q));
    assign ratio_chg = (ratio_sel != ratio_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_EMPTY;
            cnt     <= '0;
            sr      <= '0;
            ratio_q <= RATIO_16;
        end else begin
            state   <= state_n;
            cnt     <= cnt_n;
            sr      <= sr_n;
            ratio_q <= ratio_sel;
        end
    end

    // transitions and outputs
    always_comb begin
        state_n   = state;
        cnt_n     = cnt;
        sr_n      = sr;
        word_done = 1'b0;
        if (ratio_chg) begin
            // ratio-restart
            state_n = ST_EMPTY;
            cnt_n   = '0;
            sr_n    = '0;
        end else if (in_tick) begin
            unique case (state)
                ST_EMPTY: begin
                    // first-bit
                    sr_n    = {{(LANES-1){1'b0}}, in_bit};
                    cnt_n   = CW'(1);
                    state_n = ST_FILL;
                end
                ST_FILL: begin
                    sr_n = {sr[LANES-2:0], in_bit};
                    if (cnt == len_c - CW'(1)) begin
                        // word-complete
                        word_done = 1'b1;
                        cnt_n     = '0;
                        state_n   = ST_EMPTY;
                    end else begin
                        cnt_n = cnt + CW'(1);
                    end
                end
            endcase
        end
    end

    assign raw_word = sr_n;

    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < len_c);

    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_chg |=> (cnt == '0 && state == ST_EMPTY));

    p_done_in_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |-> (state == ST_FILL && in_tick));

endmodule

// File: rtl/deser_fmt.sv
module deser_fmt
    import deser_pkg::*;
#(
    parameter int LANES       = 16,
    parameter int NARROW_BASE = 6
) (
    input  logic [LANES-1:0] raw_word,
    input  ratio_e           ratio,
    input  logic             mute,
    input  logic             mirror,
    input  logic             odd_par,
    output logic [LANES-1:0] out_word,
    output logic             out_par
);
    logic [LANES-1:0] placed, muted, flipped;

    function automatic logic [LANES-1:0] low_mask(int n);
        logic [LANES-1:0] m;
        m = '0;
        for (int k = 0; k < LANES; k++)
            if (k < n) m[k] = 1'b1;
        return m;
    endfunction

    always_comb begin
        unique case (ratio)
            RATIO_16: placed = raw_word;
            RATIO_10: placed = raw_word & low_mask(10);
            RATIO_8:  placed = raw_word & low_mask(8);
            RATIO_4:  placed = (raw_word & low_mask(4)) << NARROW_BASE;
        endcase
        muted = mute ? '0 : placed;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_flip
        assign flipped[g] = muted[LANES-1-g];
    end

    assign out_word = mirror ? flipped : muted;
    assign out_par  = (^muted) ^ odd_par;

endmodule

// File: rtl/word_deser.sv
module word_deser
    import deser_pkg::*;
#(
    parameter int LANES       = 16,
    parameter int NARROW_BASE = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             rx_tick,
    input  logic             lb_bit,
    input  logic             lb_tick,
    input  logic             loop_en_n,
    input  logic [1:0]       ratio_sel,
    input  logic             mute,
    input  logic             mirror,
    input  logic             odd_par,
    output logic [LANES-1:0] par_word,
    output logic             par_bit,
    output logic             word_stb
);
    localparam logic [LANES-1:0] NARROW_MASK = LANES'(4'hF) << NARROW_BASE;

    logic             s_bit, s_tick, done;
    logic [LANES-1:0] raw, fmt_word;
    logic             fmt_par;
    ratio_e           ratio_q;

    deser_src_sel u_src (
        .rec_bit  (rx_bit),
        .rec_tick (rx_tick),
        .alt_bit  (lb_bit),
        .alt_tick (lb_tick),
        .use_alt_n(loop_en_n),
        .sel_bit  (s_bit),
        .sel_tick (s_tick)
    );

    deser_core #(.LANES(LANES)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ratio_sel(ratio_e'(ratio_sel)),
        .in_bit   (s_bit),
        .in_tick  (s_tick),
        .raw_word (raw),
        .word_done(done),
        .ratio_q  (ratio_q)
    );

    deser_fmt #(.LANES(LANES), .NARROW_BASE(NARROW_BASE)) u_fmt (
        .raw_word(raw),
        .ratio   (ratio_q),
        .mute    (mute),
        .mirror  (mirror),
        .odd_par (odd_par),
        .out_word(fmt_word),
        .out_par (fmt_par)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_word <= '0;
            par_bit  <= 1'b0;
            word_stb <= 1'b0;
        end else begin
            word_stb <= done;
            if (done) begin
                par_word <= fmt_word;
                par_bit  <= fmt_par;
            end
        end
    end

    p_stb_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |=> !word_stb);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !word_stb |-> ($stable(par_word) && $stable(par_bit)));

    p_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> ((^par_word) ^ par_bit) == $past(odd_par));

    p_mute_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && $past(mute)) |-> (par_word == '0));

    p_narrow_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && $past(ratio_sel) == 2'b00 && !$past(mirror))
            |-> ((par_word & ~NARROW_MASK) == '0));

endmodule

// File: tb/word_deser_test.sv
module word_deser_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_bit = 1'b0, rx_tick = 1'b0, lb_bit = 1'b0, lb_tick = 1'b0;
    logic        loop_en_n = 1'b1;
    logic [1:0]  ratio_sel = 2'b11;
    logic        mute = 1'b0, mirror = 1'b0, odd_par = 1'b0;
    logic [15:0] par_word;
    logic        par_bit, word_stb;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(PERIOD/2) clk = ~clk;

    word_deser uut (
        .clk(clk), .rst_n(rst_n),
        .rx_bit(rx_bit), .rx_tick(rx_tick),
        .lb_bit(lb_bit), .lb_tick(lb_tick),
        .loop_en_n(loop_en_n), .ratio_sel(ratio_sel),
        .mute(mute), .mirror(mirror), .odd_par(odd_par),
        .par_word(par_word), .par_bit(par_bit), .word_stb(word_stb)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int len_of(input logic [1:0] r);
        case (r)
            2'b11: return 16;
            2'b10: return 10;
            2'b01: return 8;
            default: return 4;
        endcase
    endfunction

    // lane map per R3, R4, R6, R7
    function automatic logic [15:0] exp_word(input logic [1:0] r, input logic [15:0] v,
                                             input logic mu, input logic mi);
        logic [15:0] w, f;
        int n;
        n = len_of(r);
        w = v & 16'((32'd1 << n) - 1);
        if (n == 4) w = w << 6;
        if (mu) w = '0;
        for (int k = 0; k < 16; k++) f[k] = w[15-k];
        return mi ? f : w;
    endfunction

    task automatic set_ratio(input logic [1:0] r);
        @(negedge clk);
        ratio_sel = r;
        @(negedge clk);
        @(negedge clk);
    endtask

    // sends n bits of v, first bit = v[n-1]; the unused path carries conflicting traffic
    task automatic send(input int n, input logic [15:0] v, input logic use_lb);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i > 0) check("R1 no strobe mid-word", 32'(word_stb), 32'd0);
            if (use_lb) begin
                lb_bit = v[n-1-i]; lb_tick = 1'b1;
                rx_bit = ~v[n-1-i]; rx_tick = (i % 2 == 0);
            end else begin
                rx_bit = v[n-1-i]; rx_tick = 1'b1;
                lb_tick = 1'b0;
            end
        end
        @(negedge clk);
        rx_tick = 1'b0; lb_tick = 1'b0;
    endtask

    task automatic word_check(input string req, input logic [1:0] r, input logic [15:0] v);
        logic [15:0] ew;
        ew = exp_word(r, v, mute, mirror);
        check({req, " R10 strobe"}, 32'(word_stb), 32'd1);
        check({req, " word"}, 32'(par_word), 32'(ew));
        check({req, " R5 parity"}, 32'(par_bit), 32'((^ew) ^ odd_par));
        @(negedge clk);
        check("R10 strobe drops", 32'(word_stb), 32'd0);
        check("R10 word holds", 32'(par_word), 32'(ew));
    endtask

    initial begin
        logic [15:0] pats [4];
        pats[0] = 16'hA5C3; pats[1] = 16'h0001; pats[2] = 16'hFFFF; pats[3] = 16'h8E41;
        repeat (3) @(negedge clk);
        check("R2 reset word", 32'(par_word), 32'd0);
        check("R2 reset strobe", 32'(word_stb), 32'd0);
        check("R2 reset parity", 32'(par_bit), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep R1 R3 R4 R5 R6 R7
        for (int r = 3; r >= 0; r--) begin
            set_ratio(2'(r));
            for (int cfg = 0; cfg < 8; cfg++) begin
                for (int p = 0; p < 4; p++) begin
                    mute = cfg[0]; mirror = cfg[1]; odd_par = cfg[2];
                    send(len_of(2'(r)), pats[p], 1'b0);
                    word_check("R3 R4 R6 R7 sweep", 2'(r), pats[p]);
                end
            end
        end
        mute = 1'b0; mirror = 1'b0; odd_par = 1'b0;

        // R8: loop-mode source with conflicting recovered traffic
        set_ratio(2'b11);
        loop_en_n = 1'b0;
        send(16, 16'h3C96, 1'b1);
        word_check("R8 loop source", 2'b11, 16'h3C96);
        // recovered ticks alone must not complete a word
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); rx_tick = 1'b1; rx_bit = 1'b1;
            check("R8 recovered ignored", 32'(word_stb), 32'd0);
        end
        @(negedge clk); rx_tick = 1'b0;
        check("R8 word unchanged", 32'(par_word), 32'h3C96);
        loop_en_n = 1'b1;

        // R9: partial word then ratio change
        set_ratio(2'b11);
        send(5, 16'h001F, 1'b0);
        check("R9 no strobe on partial", 32'(word_stb), 32'd0);
        set_ratio(2'b01);
        send(8, 16'h00B4, 1'b0);
        word_check("R9 restart", 2'b01, 16'h00B4);
        set_ratio(2'b00);
        send(2, 16'h0003, 1'b0);
        set_ratio(2'b10);
        send(10, 16'h0291, 1'b0);
        word_check("R9 restart 10", 2'b10, 16'h0291);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule